// File: doc/BRIEF.md
# Address-Range Access Watchpoint Unit

This block watches the stream of granted accesses leaving a memory arbiter and flags accesses that touch a guarded window of memory. It holds four independent watchpoints. Each one is programmed with an inclusive address window, a mask of access kinds (read, write) and a mask of the requesting clients it cares about. An access that satisfies all three conditions is a hit. On the first hit the watchpoint records the access details. It also raises a pending interrupt bit, which a global mask gates onto a single interrupt line.

Software programs and inspects the unit through a simple word-addressed register bus. The bus has a write strobe and a combinational read port. The access stream is valid-only: the unit observes each granted access in the cycle `acc_valid` is high and never applies back-pressure, so it has no ready signal. Recorded details stay frozen until software writes the watchpoint's own acknowledge register. Later hits that arrive while a record is held only add their client to the recorded client set. Pending interrupt bits are cleared separately, by writing ones to a global acknowledge register.

Top module: `watch_unit`

## Requirements
- R1: After reset every configuration register, capture register, pending bit and mask bit reads zero, and `irq` is low.
- R2: An access is a hit for a watchpoint only when all of these hold: `acc_valid` is high, and first <= `acc_addr` <= last (both bounds inclusive), and `acc_client` is below 14 with its bit set in the client mask, and the access kind is enabled in the kind mask. Kind mask bit 0 enables reads (`acc_write`=0) and bit 1 enables writes (`acc_write`=1). A client id of 14 or 15 never hits.
- R3: A hit on a watchpoint that holds no record captures a new record. The captured client set is the one-hot of the client. The record also holds the address, the kind, the client id and the 3-bit size. The info word has the valid flag at bit 31, the size at bits 10:8, the client id at bits 7:4 and the write flag at bit 0.
- R4: A hit while a record is held ORs the client's one-hot into the captured client set. The captured address, kind, first client and size are left unchanged.
- R5: A write of any value to a watchpoint's acknowledge word clears its record to all zeros. A hit in that same cycle instead starts a fresh record from that access.
- R6: Every hit sets that watchpoint's pending bit, and a single access can set the bits of several watchpoints at once.
- R7: Writing the global acknowledge word clears each pending bit whose data bit is 1. Zero bits leave their pending bit unchanged, and a hit in the same cycle keeps its bit set.
- R8: `irq` is high exactly when some pending bit has its interrupt mask bit set. The masked status word reads pending AND mask.
- R9: Register map, word addresses. Watchpoint k uses words 8k+0 (first address), 8k+1 (last address), 8k+2 (kind mask, bits 1:0), 8k+3 (client mask, bits 13:0), 8k+4 (captured clients), 8k+5 (captured address), 8k+6 (info) and 8k+7 (acknowledge, reads 0). The global words are 32 (interrupt mask, bits 3:0), 33 (masked status) and 34 (global acknowledge, reads 0). Unmapped words read 0, and writes to read-only words change nothing. Configuration writes take effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register word address (write and read) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| acc_valid | input | 1 | A granted access is present this cycle |
| acc_addr | input | 32 | Access address |
| acc_client | input | 4 | Requesting client id |
| acc_write | input | 1 | 1 for a write, 0 for a read |
| acc_size | input | 3 | Encoded access size |
| irq | output | 1 | Masked interrupt request |

## Verification
The comparator is driven with addresses one below, exactly at, inside and one above each window bound. This separates inclusive from exclusive bounds. Accesses from masked and unmasked clients, foreign ids 14 and 15, and reads against write-only watchpoints each exercise one qualifier alone. Repeated hits from new clients show whether the record is sticky or overwritten. Overlapping windows with partial interrupt masks separate pending state from the masked view. Acknowledges that collide with hits in the same cycle expose the priority between clearing and setting.

// File: rtl/watch_pkg.sv
package watch_pkg;
  localparam int REG_DW = 32;
  localparam int SLOT_WORDS = 8;

  typedef enum logic [2:0] {
    SEL_FIRST   = 3'd0,
    SEL_LAST    = 3'd1,
    SEL_KIND    = 3'd2,
    SEL_CLMASK  = 3'd3,
    SEL_CAPCL   = 3'd4,
    SEL_CAPADDR = 3'd5,
    SEL_CAPINFO = 3'd6,
    SEL_ACK     = 3'd7
  } slot_sel_e;

  localparam logic [1:0] GLB_MASK   = 2'd0;
  localparam logic [1:0] GLB_STATUS = 2'd1;
  localparam logic [1:0] GLB_ACK    = 2'd2;
endpackage

// File: rtl/watch_slot.sv
module watch_slot
  import watch_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int NUM_CLIENTS = 14,
  parameter int CID_W       = 4,
  parameter int SIZE_W      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  slot_sel_e         cfg_sel,
  input  logic [REG_DW-1:0] cfg_wdata,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [CID_W-1:0]  acc_client,
  input  logic              acc_write,
  input  logic [SIZE_W-1:0] acc_size,
  output logic              hit,
  input  slot_sel_e         rd_sel,
  output logic [REG_DW-1:0] rd_data
);
  logic [ADDR_W-1:0]      first_q, last_q;
  logic [1:0]             kind_q;
  logic [NUM_CLIENTS-1:0] clmask_q;
  logic                   cap_v;
  logic [NUM_CLIENTS-1:0] cap_cl;
  logic [ADDR_W-1:0]      cap_addr;
  logic                   cap_wr;
  logic [CID_W-1:0]       cap_first;
  logic [SIZE_W-1:0]      cap_size;
  logic [NUM_CLIENTS-1:0] client_oh;
  logic                   in_range, kind_ok, ack;

  for (genvar c = 0; c < NUM_CLIENTS; c++) begin : g_client_hot
    assign client_oh[c] = (acc_client == CID_W'(c));
  end

  assign in_range = (acc_addr >= first_q) && (acc_addr <= last_q);
  assign kind_ok  = acc_write ? kind_q[1] : kind_q[0];
  assign hit      = acc_valid && in_range && kind_ok && ((client_oh & clmask_q) != '0);
  assign ack      = cfg_we && (cfg_sel == SEL_ACK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      first_q  <= '0;
      last_q   <= '0;
      kind_q   <= '0;
      clmask_q <= '0;
    end else if (cfg_we) begin
      case (cfg_sel)
        SEL_FIRST:  first_q  <= cfg_wdata[ADDR_W-1:0];
        SEL_LAST:   last_q   <= cfg_wdata[ADDR_W-1:0];
        SEL_KIND:   kind_q   <= cfg_wdata[1:0];
        SEL_CLMASK: clmask_q <= cfg_wdata[NUM_CLIENTS-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_v     <= 1'b0;
      cap_cl    <= '0;
      cap_addr  <= '0;
      cap_wr    <= 1'b0;
      cap_first <= '0;
      cap_size  <= '0;
    end else if (hit) begin
      if (!cap_v || ack) begin
        cap_v     <= 1'b1;
        cap_cl    <= client_oh;
        cap_addr  <= acc_addr;
        cap_wr    <= acc_write;
        cap_first <= acc_client;
        cap_size  <= acc_size;
      end else begin
        cap_cl <= cap_cl | client_oh;
      end
    end else if (ack) begin
      cap_v     <= 1'b0;
      cap_cl    <= '0;
      cap_addr  <= '0;
      cap_wr    <= 1'b0;
      cap_first <= '0;
      cap_size  <= '0;
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_sel)
      SEL_FIRST:   rd_data[ADDR_W-1:0]      = first_q;
      SEL_LAST:    rd_data[ADDR_W-1:0]      = last_q;
      SEL_KIND:    rd_data[1:0]             = kind_q;
      SEL_CLMASK:  rd_data[NUM_CLIENTS-1:0] = clmask_q;
      SEL_CAPCL:   rd_data[NUM_CLIENTS-1:0] = cap_cl;
      SEL_CAPADDR: rd_data[ADDR_W-1:0]      = cap_addr;
      SEL_CAPINFO: begin
        rd_data[31]           = cap_v;
        rd_data[8 +: SIZE_W]  = cap_size;
        rd_data[4 +: CID_W]   = cap_first;
        rd_data[0]            = cap_wr;
      end
      default: rd_data = '0;
    endcase
  end

  a_r2_foreign_client: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(acc_client) >= NUM_CLIENTS) |-> !hit);
  a_r3_fresh_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_v && hit) |=> (cap_v && cap_addr == $past(acc_addr) && cap_first == $past(acc_client)));
  a_r4_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_v && hit && !ack) |=> ($stable(cap_addr) && $stable(cap_first) && $stable(cap_size) && $stable(cap_wr)));
  a_r4_client_or: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_v && hit && !ack) |=> (cap_cl == ($past(cap_cl) | $past(client_oh))));
  a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !hit) |=> (!cap_v && cap_cl == '0 && cap_addr == '0));
endmodule

// File: rtl/watch_irq.sv
module watch_irq #(
  parameter int NUM_WP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_WP-1:0] hit_vec,
  input  logic              mask_we,
  input  logic [NUM_WP-1:0] mask_wdata,
  input  logic              ack_we,
  input  logic [NUM_WP-1:0] ack_wdata,
  output logic [NUM_WP-1:0] mask_q,
  output logic [NUM_WP-1:0] status,
  output logic              irq
);
  logic [NUM_WP-1:0] pend_q;
  logic [NUM_WP-1:0] clr_bits;

  assign clr_bits = ack_we ? ack_wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      mask_q <= '0;
    end else begin
      pend_q <= (pend_q & ~clr_bits) | hit_vec;
      if (mask_we) mask_q <= mask_wdata;
    end
  end

  assign status = pend_q & mask_q;
  assign irq    = |status;

  a_r6_hit_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_vec != '0) |=> ((pend_q & $past(hit_vec)) == $past(hit_vec)));
  a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ack_we |=> ((pend_q & $past(ack_wdata & ~hit_vec)) == '0));
  a_r7_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_we && hit_vec == '0) |=> $stable(pend_q));
  a_r8_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq);
endmodule

// File: rtl/watch_unit.sv
module watch_unit
  import watch_pkg::*;
#(
  parameter int NUM_WP      = 4,
  parameter int NUM_CLIENTS = 14,
  parameter int ADDR_W      = 32,
  parameter int SIZE_W      = 3,
  localparam int CID_W      = $clog2(NUM_CLIENTS),
  localparam int REG_AW     = $clog2(NUM_WP * SLOT_WORDS * 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [CID_W-1:0]  acc_client,
  input  logic              acc_write,
  input  logic [SIZE_W-1:0] acc_size,
  output logic              irq
);
  localparam int GLB_BASE = NUM_WP * SLOT_WORDS;
  localparam int SID_W    = REG_AW - 3;

  logic [SID_W-1:0]  slot_id;
  slot_sel_e         word_sel;
  logic              in_slots, in_glb;
  logic [1:0]        glb_off;
  logic [NUM_WP-1:0] hit_vec, mask_q, status;
  logic [REG_DW-1:0] slot_rd [NUM_WP];

  assign slot_id  = reg_addr[REG_AW-1:3];
  assign word_sel = slot_sel_e'(reg_addr[2:0]);
  assign in_slots = (reg_addr < REG_AW'(GLB_BASE));
  assign in_glb   = (reg_addr >= REG_AW'(GLB_BASE)) && (reg_addr < REG_AW'(GLB_BASE + 4));
  assign glb_off  = reg_addr[1:0];

  for (genvar k = 0; k < NUM_WP; k++) begin : g_slot
    logic sel_k;
    assign sel_k = in_slots && (slot_id == SID_W'(k));
    watch_slot #(
      .ADDR_W(ADDR_W), .NUM_CLIENTS(NUM_CLIENTS), .CID_W(CID_W), .SIZE_W(SIZE_W)
    ) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_we     (reg_we && sel_k),
      .cfg_sel    (word_sel),
      .cfg_wdata  (reg_wdata),
      .acc_valid  (acc_valid),
      .acc_addr   (acc_addr),
      .acc_client (acc_client),
      .acc_write  (acc_write),
      .acc_size   (acc_size),
      .hit        (hit_vec[k]),
      .rd_sel     (word_sel),
      .rd_data    (slot_rd[k])
    );
  end

  watch_irq #(.NUM_WP(NUM_WP)) u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .hit_vec    (hit_vec),
    .mask_we    (reg_we && in_glb && glb_off == GLB_MASK),
    .mask_wdata (reg_wdata[NUM_WP-1:0]),
    .ack_we     (reg_we && in_glb && glb_off == GLB_ACK),
    .ack_wdata  (reg_wdata[NUM_WP-1:0]),
    .mask_q     (mask_q),
    .status     (status),
    .irq        (irq)
  );

  always_comb begin
    reg_rdata = '0;
    if (in_slots) begin
      for (int k = 0; k < NUM_WP; k++)
        if (slot_id == SID_W'(k)) reg_rdata = slot_rd[k];
    end else if (in_glb) begin
      case (glb_off)
        GLB_MASK:   reg_rdata[NUM_WP-1:0] = mask_q;
        GLB_STATUS: reg_rdata[NUM_WP-1:0] = status;
        default:    reg_rdata = '0;
      endcase
    end
  end

  a_r8_irq_follows_status: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (status != '0));
  a_r9_ack_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_slots && word_sel == SEL_ACK) |-> (reg_rdata == '0));
endmodule

// File: tb/test_watch_unit.sv
`timescale 1ns/1ps
module test_watch_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = '0;
  logic [3:0]  acc_client = '0;
  logic        acc_write = 1'b0;
  logic [2:0]  acc_size = '0;
  logic        irq;

  always #2.5 clk = ~clk;

  watch_unit i_watch_unit (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_valid(acc_valid),
    .acc_addr(acc_addr), .acc_client(acc_client), .acc_write(acc_write),
    .acc_size(acc_size), .irq(irq)
  );

  // behavioural reference state
  logic [31:0] m_lo[4], m_hi[4], m_ccl[4], m_caddr[4];
  logic [1:0]  m_kind[4];
  logic [13:0] m_cm[4];
  logic        m_cv[4], m_cwr[4];
  logic [3:0]  m_cfirst[4];
  logic [2:0]  m_csz[4];
  logic [3:0]  m_pend, m_mask;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  task automatic model_reset();
    for (int w = 0; w < 4; w++) begin
      m_lo[w] = 0; m_hi[w] = 0; m_ccl[w] = 0; m_caddr[w] = 0; m_kind[w] = 0;
      m_cm[w] = 0; m_cv[w] = 0; m_cwr[w] = 0; m_cfirst[w] = 0; m_csz[w] = 0;
    end
    m_pend = 0; m_mask = 0;
  endtask

  task automatic model_step();
    bit h[4];
    int a;
    a = int'(reg_addr);
    for (int w = 0; w < 4; w++) begin
      h[w] = acc_valid && (m_lo[w] <= acc_addr) && (acc_addr <= m_hi[w]) &&
             (acc_client < 14) && m_cm[w][acc_client] &&
             (acc_write ? m_kind[w][1] : m_kind[w][0]);
    end
    for (int w = 0; w < 4; w++) begin
      bit ackw;
      ackw = reg_we && (a < 32) && (a / 8 == w) && (a % 8 == 7);
      if (h[w]) begin
        if (!m_cv[w] || ackw) begin
          m_cv[w] = 1; m_ccl[w] = 32'd1 << acc_client; m_caddr[w] = acc_addr;
          m_cwr[w] = acc_write; m_cfirst[w] = acc_client; m_csz[w] = acc_size;
        end else begin
          m_ccl[w] = m_ccl[w] | (32'd1 << acc_client);
        end
      end else if (ackw) begin
        m_cv[w] = 0; m_ccl[w] = 0; m_caddr[w] = 0; m_cwr[w] = 0; m_cfirst[w] = 0; m_csz[w] = 0;
      end
    end
    if (reg_we && a == 34) m_pend = m_pend & ~reg_wdata[3:0];
    for (int w = 0; w < 4; w++) if (h[w]) m_pend[w] = 1'b1;
    if (reg_we) begin
      if (a < 32) begin
        case (a % 8)
          0: m_lo[a/8] = reg_wdata;
          1: m_hi[a/8] = reg_wdata;
          2: m_kind[a/8] = reg_wdata[1:0];
          3: m_cm[a/8] = reg_wdata[13:0];
          default: ;
        endcase
      end else if (a == 32) m_mask = reg_wdata[3:0];
    end
  endtask

  function automatic logic [31:0] mread(int a);
    logic [31:0] v;
    v = 0;
    if (a < 32) begin
      case (a % 8)
        0: v = m_lo[a/8];
        1: v = m_hi[a/8];
        2: v = {30'd0, m_kind[a/8]};
        3: v = {18'd0, m_cm[a/8]};
        4: v = m_ccl[a/8];
        5: v = m_caddr[a/8];
        6: v = ({31'd0, m_cv[a/8]} << 31) | ({29'd0, m_csz[a/8]} << 8) |
               ({28'd0, m_cfirst[a/8]} << 4) | {31'd0, m_cwr[a/8]};
        default: v = 0;
      endcase
    end else if (a == 32) v = {28'd0, m_mask};
    else if (a == 33) v = {28'd0, m_pend & m_mask};
    return v;
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // every clock goes through tick: irq compared against the model each cycle
  task automatic tick();
    @(posedge clk);
    if (rst_n) model_step();
    @(negedge clk);
    check("R8 irq", {31'd0, irq}, {31'd0, |(m_pend & m_mask)});
    reg_we = 0; acc_valid = 0;
  endtask

  task automatic wr(int a, logic [31:0] d);
    reg_addr = 6'(a); reg_wdata = d; reg_we = 1; tick();
  endtask

  task automatic acc(logic [31:0] ad, int cl, bit w, int sz);
    acc_addr = ad; acc_client = 4'(cl); acc_write = w; acc_size = 3'(sz); acc_valid = 1; tick();
  endtask

  task automatic rd(int a, string tag);
    reg_addr = 6'(a); #1;
    check(tag, reg_rdata, mread(a));
  endtask

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1: reset state
    for (int a = 0; a < 36; a++) rd(a, "R1 reset value");
    check("R1 irq low", {31'd0, irq}, 32'd0);

    // R9: program watchpoint 0 and read back
    wr(0, 32'h0000_1000); wr(1, 32'h0000_1FFF); wr(2, 32'h2); wr(3, 32'h0008); wr(32, 32'h1);
    for (int a = 0; a < 4; a++) rd(a, "R9 config readback");
    rd(32, "R9 mask readback");
    check("R9 explicit first", reg_rdata, 32'h1);

    // R2: boundaries and qualifiers
    acc(32'h0FFF, 3, 1, 2); rd(33, "R2 below first");
    check("R2 below first no status", reg_rdata, 32'd0);
    acc(32'h1500, 3, 0, 2); rd(33, "R2 read not enabled");
    acc(32'h1500, 4, 1, 2); rd(33, "R2 client not in mask");
    acc(32'h1000, 3, 1, 2); rd(33, "R2 hit at first");
    check("R6 status bit0", reg_rdata, 32'h1);
    rd(4, "R3 clients"); check("R3 clients onehot", reg_rdata, 32'h8);
    rd(5, "R3 address"); rd(6, "R3 info");
    check("R3 info word", reg_rdata, 32'h8000_0231);

    // R4: later hits only add clients
    wr(3, 32'h0028);
    acc(32'h1FFF, 5, 1, 4); rd(4, "R4 clients OR");
    check("R4 clients value", reg_rdata, 32'h28);
    rd(5, "R4 address held"); rd(6, "R4 info held");
    acc(32'h2000, 5, 1, 1); rd(4, "R2 above last");

    // R7: global acknowledge
    wr(34, 32'h0); rd(33, "R7 zero ack ignored");
    check("R7 zero ack status", reg_rdata, 32'h1);
    wr(34, 32'h1); rd(33, "R7 ack clears");
    check("R7 ack status", reg_rdata, 32'h0);
    rd(6, "R7 record kept");

    // R5: per-watchpoint acknowledge
    wr(7, 32'h0); rd(6, "R5 info cleared"); rd(4, "R5 clients cleared");
    check("R5 info zero", reg_rdata, 32'd0);
    reg_addr = 6'd7; reg_wdata = 0; reg_we = 1;
    acc(32'h1800, 5, 1, 3); rd(6, "R5 ack with hit recaptures"); rd(5, "R5 new address");

    // R6/R8: overlapping windows, partial mask
    for (int w = 1; w < 4; w++) begin
      wr(8*w, 32'h4000); wr(8*w+1, 32'h4FFF); wr(8*w+2, 32'h3); wr(8*w+3, 32'h3FFF);
    end
    wr(34, 32'hF); wr(32, 32'h4);
    acc(32'h4800, 13, 0, 0);
    rd(33, "R8 masked status"); check("R8 status only bit2", reg_rdata, 32'h4);
    wr(32, 32'hE); rd(33, "R6 multi pending"); check("R6 three bits", reg_rdata, 32'hE);
    wr(32, 32'h0); check("R8 irq masked off", {31'd0, irq}, 32'd0);
    wr(32, 32'hF);

    // R2: foreign client ids
    wr(34, 32'hF); wr(11, 32'h3FFF);
    acc(32'h4100, 14, 1, 0); acc(32'h4100, 15, 0, 0);
    rd(33, "R2 foreign id"); check("R2 foreign status", reg_rdata, 32'h0);

    // R7: ack colliding with hit keeps the bit
    acc_addr = 32'h4200; acc_client = 4'd2; acc_write = 1; acc_size = 3'd1; acc_valid = 1;
    wr(34, 32'h2); rd(33, "R7 hit wins"); check("R7 hit wins value", reg_rdata & 32'h2, 32'h2);

    // R9: read-only and unmapped words
    wr(13, 32'hDEAD_BEEF); rd(13, "R9 read-only capture addr");
    wr(33, 32'hF); rd(33, "R9 status not writable");
    rd(35, "R9 unmapped"); rd(40, "R9 unmapped high"); rd(15, "R9 ack reads zero");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule